// File: doc/BRIEF.md
# Streaming SPI Slave Word Engine

This block is an SPI slave clocked by a fast system clock. The serial lines (clock, active-low select and master-out data) are brought into the system clock domain through two-flop synchronizers. Every transition of the synchronized serial clock is then classified as a sample edge or a change edge. The clock polarity and phase are chosen by parameters. Data moves most significant bit first, in words of `WORD_W` bits.

User logic loads the next outgoing word into a holding register with a one-cycle write strobe. Each fully received word is handed back with a one-cycle valid pulse. While the select line stays low, words follow each other with no gap. Shortly before each word ends, the engine raises a one-cycle request so that the user can load the next word in time. If the user does not answer, the held word goes out again.

While the slave is deselected, the slave-out line shows the top bit of the held word. A registered select moves the output over to the shift register without a glitch.

Top module: `spi_stream_slave`

## Requirements
- R1: With CPOL=0, the leading edge of SCK is its rising edge; with CPOL=1 it is the falling edge. MOSI is sampled on the leading edge when CPHA=0 and on the trailing edge when CPHA=1. All four combinations are chosen by parameters.
- R2: MISO changes only on the edge opposite to the sample edge, so a master sampling on the sample edge reads each transmit bit in turn.
- R3: Words are `WORD_W` bits, MSB first. After the last sample edge of a word, `rx_word` holds the received word and `rx_valid` is high for exactly one system clock.
- R4: While `spi_ssel_n` is high, `spi_miso` equals bit `WORD_W-1` of the held transmit word. The switch to the shift register happens through a registered select, and with CPHA=1 MISO does not change in the cycle of that switch.
- R5: While `spi_ssel_n` stays low, consecutive words are received and transmitted back to back. The bit counter wraps from the last bit to the first with no deselect in between.
- R6: `tx_req` pulses high for exactly one system clock when `WORD_W-1` bits of the current word have been sampled, once per word.
- R7: A word written with `tx_wr` is held until the next write. If no write follows a request, the next word transmitted is the previous held word, not zeros.
- R8: A synchronous reset clears the held word, `rx_word`, `rx_valid`, `tx_req` and MISO to zero.
- R9: Raising `spi_ssel_n` in the middle of a word discards that partial word without an `rx_valid` pulse. The next selection starts again at the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst | input | 1 | Synchronous reset, active high |
| spi_sck | input | 1 | Serial clock from the master |
| spi_ssel_n | input | 1 | Slave select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| tx_word | input | WORD_W | Next word to transmit |
| tx_wr | input | 1 | Write strobe for `tx_word` |
| tx_req | output | 1 | One-cycle request for the next transmit word |
| rx_word | output | WORD_W | Last complete received word |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` is updated |

## Verification
On every cycle, the embedded properties check the following:
- the single-cycle width of the request and valid pulses;
- that a sample edge and a change edge never coincide;
- that the held word stays unchanged without a write;
- that the output select drops and the counter clears on deselect;
- that MISO holds steady when the select switches with CPHA=1.

Other behaviour is visible only from the bench's master transfers, run in all four modes:
- the bit order and the edge on which each bit appears;
- back-to-back streaming with user refill;
- resending the held word when the request goes unanswered;
- discarding a word cut short by deselect.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign chain_d[s] = din;
            end else begin : g_next
                assign chain_d[s] = chain_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/spi_edge_sel.sv
module spi_edge_sel #(
    parameter bit CPOL = 1'b0,
    parameter bit CPHA = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_s,
    output logic sample_ev,
    output logic change_ev
);

    logic sck_d, sck_q;
    logic lead_ev, trail_ev;

    always_comb begin
        sck_d    = sck_s;
        lead_ev  = (sck_s != sck_q) && (sck_s != CPOL);
        trail_ev = (sck_s != sck_q) && (sck_s == CPOL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= CPOL;
        end else begin
            sck_q <= sck_d;
        end
    end

    generate
        if (CPHA == 1'b0) begin : g_pha0
            assign sample_ev = lead_ev;
            assign change_ev = trail_ev;
        end else begin : g_pha1
            assign sample_ev = trail_ev;
            assign change_ev = lead_ev;
        end
    endgenerate

    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(sample_ev && change_ev)); // R2

endmodule

// File: rtl/spi_user_port.sv
module spi_user_port #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] hold_o
);

    logic [WORD_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = wr ? word : hold_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign hold_o = hold_q;

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(hold_q)); // R7

endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
    import spi_stream_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter bit CPHA   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_act,
    input  logic              mosi_bit,
    input  logic              sample_ev,
    input  logic              change_ev,
    input  logic [WORD_W-1:0] hold_word,
    output logic              miso_o,
    output logic              tx_req_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(WORD_W - 2);

    typedef struct packed {
        eng_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              use_sr;
        logic [WORD_W-1:0] tx_sr;
        logic [WORD_W-1:0] rx_sr;
        logic [WORD_W-1:0] rx_word;
        logic              rx_valid;
        logic              tx_req;
    } eng_t;

    eng_t eng_d, eng_q;
    logic word_end;

    assign word_end = sample_ev && (eng_q.cnt == LAST_BIT);

    always_comb begin
        case (eng_q.st)
            ENG_IDLE: begin
                eng_d.st       = sel_act ? ENG_RUN : ENG_IDLE;
                eng_d.cnt      = '0;
                eng_d.use_sr   = 1'b0;
                eng_d.tx_sr    = hold_word;
                eng_d.rx_sr    = eng_q.rx_sr;
                eng_d.rx_word  = eng_q.rx_word;
                eng_d.rx_valid = 1'b0;
                eng_d.tx_req   = 1'b0;
            end
            ENG_RUN: begin
                if (!sel_act) begin
                    eng_d.st       = ENG_IDLE;
                    eng_d.cnt      = '0;
                    eng_d.use_sr   = 1'b0;
                    eng_d.tx_sr    = hold_word;
                    eng_d.rx_sr    = eng_q.rx_sr;
                    eng_d.rx_word  = eng_q.rx_word;
                    eng_d.rx_valid = 1'b0;
                    eng_d.tx_req   = 1'b0;
                end else begin
                    eng_d.st       = ENG_RUN;
                    eng_d.cnt      = sample_ev ? (word_end ? '0 : eng_q.cnt + 1'b1)
                                               : eng_q.cnt;
                    eng_d.use_sr   = eng_q.use_sr | change_ev;
                    eng_d.tx_sr    = change_ev ? ((eng_q.cnt == '0) ? hold_word
                                                  : {eng_q.tx_sr[WORD_W-2:0], 1'b0})
                                               : eng_q.tx_sr;
                    eng_d.rx_sr    = sample_ev ? {eng_q.rx_sr[WORD_W-2:0], mosi_bit}
                                               : eng_q.rx_sr;
                    eng_d.rx_word  = word_end ? {eng_q.rx_sr[WORD_W-2:0], mosi_bit}
                                              : eng_q.rx_word;
                    eng_d.rx_valid = word_end;
                    eng_d.tx_req   = sample_ev && (eng_q.cnt == PRE_LAST);
                end
            end
            default: begin
                eng_d.st       = ENG_IDLE;
                eng_d.cnt      = '0;
                eng_d.use_sr   = 1'b0;
                eng_d.tx_sr    = hold_word;
                eng_d.rx_sr    = eng_q.rx_sr;
                eng_d.rx_word  = eng_q.rx_word;
                eng_d.rx_valid = 1'b0;
                eng_d.tx_req   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_q.st       <= ENG_IDLE;
            eng_q.cnt      <= '0;
            eng_q.use_sr   <= 1'b0;
            eng_q.tx_sr    <= '0;
            eng_q.rx_sr    <= '0;
            eng_q.rx_word  <= '0;
            eng_q.rx_valid <= 1'b0;
            eng_q.tx_req   <= 1'b0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign miso_o     = eng_q.use_sr ? eng_q.tx_sr[WORD_W-1] : hold_word[WORD_W-1];
    assign tx_req_o   = eng_q.tx_req;
    assign rx_word_o  = eng_q.rx_word;
    assign rx_valid_o = eng_q.rx_valid;

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_req_o |=> !tx_req_o); // R6

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o); // R3

    AST_SEL_DROP: assert property (@(posedge clk) disable iff (rst)
        !sel_act |=> !eng_q.use_sr); // R4

    AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (eng_q.st == ENG_RUN && !sel_act) |=> (eng_q.cnt == '0 && !rx_valid_o)); // R9

    generate
        if (CPHA == 1'b1) begin : g_glitch_chk
            AST_NO_GLITCH: assert property (@(posedge clk) disable iff (rst)
                $rose(eng_q.use_sr) |-> (miso_o == $past(miso_o))); // R4
        end
    endgenerate

endmodule

// File: rtl/spi_stream_slave.sv
module spi_stream_slave #(
    parameter int WORD_W = 32,
    parameter bit CPOL   = 1'b0,
    parameter bit CPHA   = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_ssel_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_wr,
    output logic              tx_req,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);

    localparam logic [2:0] PIN_RST = {CPOL, 1'b1, 1'b0};

    logic [2:0]        pins_s;
    logic              sample_ev, change_ev;
    logic [WORD_W-1:0] hold_word;

    spi_pin_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({spi_sck, spi_ssel_n, spi_mosi}),
        .dout(pins_s)
    );

    spi_edge_sel #(
        .CPOL(CPOL),
        .CPHA(CPHA)
    ) u_edges (
        .clk      (clk),
        .rst      (rst),
        .sck_s    (pins_s[2]),
        .sample_ev(sample_ev),
        .change_ev(change_ev)
    );

    spi_user_port #(
        .WORD_W(WORD_W)
    ) u_user (
        .clk   (clk),
        .rst   (rst),
        .wr    (tx_wr),
        .word  (tx_word),
        .hold_o(hold_word)
    );

    spi_word_engine #(
        .WORD_W(WORD_W),
        .CPHA  (CPHA)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .sel_act   (~pins_s[1]),
        .mosi_bit  (pins_s[0]),
        .sample_ev (sample_ev),
        .change_ev (change_ev),
        .hold_word (hold_word),
        .miso_o    (spi_miso),
        .tx_req_o  (tx_req),
        .rx_word_o (rx_word),
        .rx_valid_o(rx_valid)
    );

endmodule

// File: tb/spi_stream_slave_tb.sv
`timescale 1ns/1ps
module spi_stream_slave_tb;

    localparam int W = 16;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [3:0] sck    = 4'b1100;
    logic [3:0] ssel_n = 4'b1111;
    logic [3:0] mosi   = 4'b0000;
    logic [3:0] miso;
    logic [3:0] tx_wr  = 4'b0000;
    logic [3:0] tx_req;
    logic [3:0] rx_valid;
    logic [W-1:0] tx_word [4];
    logic [W-1:0] rx_word [4];

    generate
        for (genvar g = 0; g < 4; g++) begin : g_mode
            spi_stream_slave #(
                .WORD_W(W),
                .CPOL  (1'((g / 2) % 2)),
                .CPHA  (1'(g % 2))
            ) u_dut (
                .clk       (clk),
                .rst       (rst),
                .spi_sck   (sck[g]),
                .spi_ssel_n(ssel_n[g]),
                .spi_mosi  (mosi[g]),
                .spi_miso  (miso[g]),
                .tx_word   (tx_word[g]),
                .tx_wr     (tx_wr[g]),
                .tx_req    (tx_req[g]),
                .rx_word   (rx_word[g]),
                .rx_valid  (rx_valid[g])
            );
        end
    endgenerate

    int n_chk = 0;
    int n_err = 0;

    // user-side state: tasks write *_seq / feed_*, the responder writes the rest
    logic [W-1:0] pend_word [4];
    int           wr_seq  [4];
    int           wr_done [4];
    logic [W-1:0] feed_q  [4][16];
    int           feed_n  [4];
    int           feed_idx[4];
    int           req_cnt [4];
    int           rx_cnt  [4];
    logic [W-1:0] rx_log  [4][16];
    logic [W-1:0] mst_out [8];
    logic [W-1:0] mst_in  [8];

    initial begin
        for (int m = 0; m < 4; m++) begin
            tx_word[m] = '0; pend_word[m] = '0;
            wr_seq[m] = 0; wr_done[m] = 0; feed_n[m] = 0; feed_idx[m] = 0;
            req_cnt[m] = 0; rx_cnt[m] = 0;
        end
        forever begin
            @(negedge clk);
            for (int m = 0; m < 4; m++) begin
                if (wr_done[m] != wr_seq[m]) begin
                    tx_word[m] = pend_word[m];
                    tx_wr[m]   = 1'b1;
                    wr_done[m] = wr_seq[m];
                end else if (tx_req[m] && feed_idx[m] < feed_n[m]) begin
                    tx_word[m] = feed_q[m][feed_idx[m] % 16];
                    tx_wr[m]   = 1'b1;
                    feed_idx[m]++;
                end else begin
                    tx_wr[m] = 1'b0;
                end
                if (!rst && tx_req[m]) req_cnt[m]++;
                if (!rst && rx_valid[m]) begin
                    rx_log[m][rx_cnt[m] % 16] = rx_word[m];
                    rx_cnt[m]++;
                end
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic user_write(input int m, input logic [W-1:0] w);
        pend_word[m] = w;
        wr_seq[m]++;
        wait (wr_done[m] == wr_seq[m]);
        wait_clk(3);
    endtask

    // master drives nbits from mst_out and records MISO into mst_in
    task automatic spi_run(input int m, input int nbits);
        bit cpol;
        bit cpha;
        cpol = bit'((m / 2) % 2);
        cpha = bit'(m % 2);
        ssel_n[m] = 1'b0;
        wait_clk(H);
        for (int b = 0; b < nbits; b++) begin
            int wi;
            int bi;
            wi = b / W;
            bi = W - 1 - (b % W);
            if (!cpha) begin
                mosi[m] = mst_out[wi][bi];
                wait_clk(H);
                sck[m] = ~cpol;
                mst_in[wi][bi] = miso[m];
                wait_clk(H);
                sck[m] = cpol;
            end else begin
                sck[m]  = ~cpol;
                mosi[m] = mst_out[wi][bi];
                wait_clk(H);
                sck[m] = cpol;
                mst_in[wi][bi] = miso[m];
                wait_clk(H);
            end
        end
        wait_clk(H);
        ssel_n[m] = 1'b1;
        wait_clk(2 * H);
    endtask

    task automatic t_reset();
        for (int m = 0; m < 4; m++) begin
            chk(rx_valid[m] == 1'b0, "R8", "rx_valid after reset", W'(rx_valid[m]), '0);
            chk(tx_req[m] == 1'b0, "R8", "tx_req after reset", W'(tx_req[m]), '0);
            chk(miso[m] == 1'b0, "R8", "miso after reset", W'(miso[m]), '0);
            chk(rx_word[m] == '0, "R8", "rx_word after reset", rx_word[m], '0);
        end
    endtask

    task automatic t_preload(input int m);
        user_write(m, 16'h8001);
        chk(miso[m] == 1'b1, "R4", "preload msb=1", W'(miso[m]), W'(1));
        user_write(m, 16'h7FFE);
        chk(miso[m] == 1'b0, "R4", "preload msb=0", W'(miso[m]), W'(0));
    endtask

    task automatic t_single(input int m);
        int rb;
        int qb;
        logic [W-1:0] a;
        a = 16'hA5C3 ^ W'(m);
        rb = rx_cnt[m];
        qb = req_cnt[m];
        feed_n[m] = feed_idx[m];
        user_write(m, a);
        mst_out[0] = 16'h3C5A + W'(m);
        spi_run(m, W);
        chk(rx_cnt[m] - rb == 1, "R3", "one rx_valid pulse", W'(rx_cnt[m] - rb), W'(1));
        chk(rx_log[m][rb % 16] == mst_out[0], "R1", "mosi word sampled", rx_log[m][rb % 16], mst_out[0]);
        chk(mst_in[0] == a, "R2", "miso word seen by master", mst_in[0], a);
        chk(req_cnt[m] - qb == 1, "R6", "one request per word", W'(req_cnt[m] - qb), W'(1));
    endtask

    task automatic t_stream(input int m);
        int rb;
        int qb;
        logic [W-1:0] a;
        logic [W-1:0] c1;
        logic [W-1:0] c2;
        a  = 16'h1234 + W'(m);
        c1 = 16'hBEEF ^ W'(m);
        c2 = 16'h0F0F + W'(m);
        rb = rx_cnt[m];
        qb = req_cnt[m];
        user_write(m, a);
        feed_q[m][feed_idx[m] % 16]       = c1;
        feed_q[m][(feed_idx[m] + 1) % 16] = c2;
        feed_n[m] = feed_idx[m] + 2;
        mst_out[0] = 16'hC001; mst_out[1] = 16'h5AA5; mst_out[2] = 16'h8421 + W'(m);
        spi_run(m, 3 * W);
        chk(rx_cnt[m] - rb == 3, "R5", "three words received", W'(rx_cnt[m] - rb), W'(3));
        for (int k = 0; k < 3; k++)
            chk(rx_log[m][(rb + k) % 16] == mst_out[k], "R5", "streamed rx word",
                rx_log[m][(rb + k) % 16], mst_out[k]);
        chk(mst_in[0] == a, "R5", "streamed tx word 0", mst_in[0], a);
        chk(mst_in[1] == c1, "R5", "streamed tx word 1", mst_in[1], c1);
        chk(mst_in[2] == c2, "R5", "streamed tx word 2", mst_in[2], c2);
        chk(req_cnt[m] - qb == 3, "R6", "request per streamed word", W'(req_cnt[m] - qb), W'(3));
    endtask

    task automatic t_repeat(input int m);
        logic [W-1:0] a;
        a = 16'hD00D ^ W'(m);
        feed_n[m] = feed_idx[m];
        user_write(m, a);
        mst_out[0] = 16'h0001; mst_out[1] = 16'hFFFE;
        spi_run(m, 2 * W);
        chk(mst_in[0] == a, "R7", "first word", mst_in[0], a);
        chk(mst_in[1] == a, "R7", "unanswered request repeats word", mst_in[1], a);
    endtask

    task automatic t_abort(input int m);
        int rb;
        logic [W-1:0] b;
        b = 16'h6C39 + W'(m);
        feed_n[m] = feed_idx[m];
        rb = rx_cnt[m];
        mst_out[0] = 16'hFFFF;
        spi_run(m, 5);
        chk(rx_cnt[m] == rb, "R9", "no rx_valid for partial word", W'(rx_cnt[m] - rb), W'(0));
        user_write(m, b);
        mst_out[0] = 16'h2B4D ^ W'(m);
        spi_run(m, W);
        chk(rx_log[m][rb % 16] == mst_out[0], "R9", "rx after abort", rx_log[m][rb % 16], mst_out[0]);
        chk(mst_in[0] == b, "R9", "tx after abort", mst_in[0], b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R5 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        t_reset();
        t_preload(0);
        t_preload(3);
        for (int m = 0; m < 4; m++) begin
            t_single(m);
            t_stream(m);
            t_repeat(m);
            t_abort(m);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule